// File: doc/BRIEF.md
# Converter Serial Read Port

This block is the serial slave side of a 16-bit sampling converter. A start request launches a conversion that lasts a fixed number of system clock cycles. A busy flag stays high for that whole period. When the period ends, the parallel result is taken from a test input and the busy flag drops. A counter stands in for the analog conversion.

A host reads the result one bit per serial clock pulse while both the chip-select and read-enable inputs are low. Two read modes are available.

- **Read-after mode:** the host collects the new result once busy has fallen. A serial input lets several ports form a chain. Bits captured on the serial input follow the local word out of the serial output, so the next device's word comes right after the local LSB.
- **Read-during mode:** the host collects the previous result while the next conversion is running. The serial input is ignored in this mode. A one-cycle error pulse warns the host when a read started in this mode is still short of 16 bits at the moment the conversion finishes.

The serial clock, select, read-enable and serial data inputs are asynchronous. Each passes through a two-stage synchronizer. The serial clock therefore must run at no more than a quarter of the system clock rate.

Top module: `adc_serial_port`

## Requirements
- R1: While reset is held and right after it, `busy`, `rd_error` and `sdout` are all 0.
- R2: `conv_start` sampled high while `busy` is low raises `busy` for exactly CONV_CYCLES system clock cycles. At the edge where `busy` falls, the value on `sample_in` becomes the stored result.
- R3: A bit is consumed only on a serial clock falling edge seen while both `cs_n` and `rd_n` are low. Bits leave MSB first, one per falling edge. The first bit is on `sdout` as soon as the select has been seen low. `sdout` is 0 while the select is high.
- R4: Each high-to-low transition of `cs_n` reloads the outgoing word from the stored result and restarts at its MSB.
- R5: With `mode_sel` = 0 (read-after), `sdin` is captured on serial clock rising edges and shifted in behind the local word. The 17th bit on `sdout` is therefore the first bit that `sdin` carried.
- R6: With `mode_sel` = 1 (read-during), a read started while `busy` is high delivers the result of the previous conversion.
- R7: In read-during mode, if a read started while `busy` is high has consumed fewer than 16 bits when the conversion completes, `rd_error` is high for exactly one cycle, the cycle in which `busy` has just fallen.
- R8: With `mode_sel` = 1, `sdin` has no effect: every bit after the 16th is 0.
- R9: `conv_start` while `busy` is high is ignored. The running conversion keeps its original length.
- R10: A 16th falling edge detected in the same system cycle as the completion of the conversion counts as a finished read, and no error is flagged.
- R11: A read begun after a conversion may continue across the start and end of the next conversion without `rd_error`, and it delivers the word loaded when the select fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start | input | 1 | Conversion start request, synchronous |
| mode_sel | input | 1 | 0 = read-after, 1 = read-during |
| sample_in | input | 16 | Parallel value taken as the result at conversion end |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read enable, active low, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| sdin | input | 1 | Chain input from the next device |
| sdout | output | 1 | Serial data out |
| busy | output | 1 | High while a conversion runs |
| rd_error | output | 1 | One-cycle pulse: read-during read left incomplete |

## Verification
The two functions that can meet in one cycle are the completion of a conversion and the detected falling edge that consumes the 16th bit of a read-during read. The bench sweeps the start of a 16-bit read across twelve consecutive cycle offsets relative to conversion start. This walks the final falling edge from before the completion cycle, through it, and past it. A behavioural queue model predicts `rd_error`, `busy` and `sdout` for every clock and is compared cycle by cycle. Under R10 the coincident case must show no error pulse, and every later case must show exactly one.

// File: rtl/adc_sp_pkg.sv
// Package: shared types for the converter serial read port.
// Assumes: one mode bit from the host side, held stable during a read.
package adc_sp_pkg;
    typedef enum logic {
        RD_AFTER  = 1'b0,
        RD_DURING = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/sp_sync_bank.sv
// Module: multi-bit synchronizer bank for asynchronous host pins.
// Assumes: each bit is independent; skew between bits is tolerated by the
// caller because all bits see the same number of stages.
module sp_sync_bank #(
    parameter int         N         = 4,
    parameter int         STAGES    = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stage [STAGES];

    // Shift every input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/sp_conv_timer.sv
// Module: conversion stand-in. Counts a fixed period, then latches the
// parallel result. Assumes start is synchronous to clk.
module sp_conv_timer #(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] sample,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    localparam int               CNT_W = $clog2(CONV_CYCLES);
    localparam logic [CNT_W-1:0] LOAD  = CNT_W'(CONV_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Run the period counter and capture the result at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            result <= '0;
        end else if (busy) begin
            if (cnt == '0) begin
                busy   <= 1'b0;
                result <= sample;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= LOAD;
        end
    end

    // Last busy cycle: the result lands at the coming edge.
    assign done = busy && (cnt == '0);

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && cnt == LOAD));
    p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |=> busy);
    p_result_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |=> $stable(result));
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/sp_read_shifter.sv
// Module: serial output engine. Detects serial clock edges on synchronized
// inputs, shifts the word out on falling edges, captures the chain input on
// rising edges, and flags an incomplete read-during read.
// Assumes: inputs already synchronized; serial clock <= clk/4.
module sp_read_shifter
    import adc_sp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rd_mode_e          mode,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] result,
    input  logic              sclk_s,
    input  logic              cs_s,
    input  logic              rd_s,
    input  logic              sdin_s,
    output logic              sdout,
    output logic              rd_error
);
    localparam int               CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

    logic              sclk_d, cs_d;
    logic              rise, fall, reload, enable, shift_en, capture;
    logic              hold, armed, complete_now;
    logic [DATA_W-1:0] sh;
    logic [CNT_W-1:0]  bitcnt;

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
        end
    end

    assign rise     = sclk_s & ~sclk_d;
    assign fall     = ~sclk_s & sclk_d;
    assign reload   = ~cs_s & cs_d;
    assign enable   = ~cs_s & ~rd_s;
    assign shift_en = fall & enable & ~reload;
    assign capture  = rise & enable;

    // Capture the chain input on rising edges; blocked in read-during mode.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold <= 1'b0;
        else if (capture) hold <= (mode == RD_AFTER) ? sdin_s : 1'b0;
    end

    // Load on select fall, shift toward MSB on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n)        sh <= '0;
        else if (reload)   sh <= result;
        else if (shift_en) sh <= {sh[DATA_W-2:0], hold};
    end

    // Count consumed bits, saturating at a full word.
    always_ff @(posedge clk) begin
        if (!rst_n)                         bitcnt <= '0;
        else if (reload)                    bitcnt <= '0;
        else if (shift_en && bitcnt != FULL) bitcnt <= bitcnt + 1'b1;
    end

    // Arm the error check for reads that begin while converting in read-during mode.
    always_ff @(posedge clk) begin
        if (!rst_n)      armed <= 1'b0;
        else if (done)   armed <= 1'b0;
        else if (reload) armed <= busy && (mode == RD_DURING);
    end

    // A bit consumed in the completion cycle itself still counts.
    assign complete_now = (bitcnt == FULL) || (bitcnt == LAST && shift_en);

    // Emit the one-cycle error pulse together with busy falling.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_error <= 1'b0;
        else        rd_error <= done && armed && !complete_now;
    end

    assign sdout = cs_s ? 1'b0 : sh[DATA_W-1];

    p_bits_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= FULL);
    p_no_shift_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !reload) |=> $stable(sh));
    p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_error |=> !rd_error);
    p_err_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_error |-> $past(armed));
    p_sdin_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && mode == RD_DURING) |=> !hold);
endmodule

// File: rtl/adc_serial_port.sv
// Module: top of the converter serial read port. Synchronizes host pins,
// runs the conversion stand-in and the serial output engine.
// Assumes: conv_start and mode_sel are synchronous to clk.
module adc_serial_port
    import adc_sp_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic              mode_sel,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              sclk,
    input  logic              sdin,
    output logic              sdout,
    output logic              busy,
    output logic              rd_error
);
    localparam int       PINS    = 4;
    localparam logic [PINS-1:0] PIN_IDLE = 4'b0110;

    logic [PINS-1:0]   pins_s;
    logic              done;
    logic [DATA_W-1:0] result;
    rd_mode_e          mode;

    assign mode = rd_mode_e'(mode_sel);

    sp_sync_bank #(.N(PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sdin, rd_n, cs_n, sclk}),
        .q     (pins_s)
    );

    sp_conv_timer #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (conv_start),
        .sample (sample_in),
        .busy   (busy),
        .done   (done),
        .result (result)
    );

    sp_read_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .busy     (busy),
        .done     (done),
        .result   (result),
        .sclk_s   (pins_s[0]),
        .cs_s     (pins_s[1]),
        .rd_s     (pins_s[2]),
        .sdin_s   (pins_s[3]),
        .sdout    (sdout),
        .rd_error (rd_error)
    );

    p_err_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_error |-> $fell(busy));
endmodule

// File: tb/adc_serial_port_tb.sv
module adc_serial_port_tb_top;
    localparam int DW   = 16;
    localparam int CONV = 200;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_start = 1'b0;
    logic          mode_sel = 1'b0;
    logic [DW-1:0] sample_in = '0;
    logic          cs_n = 1'b1, rd_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
    logic          sdout, busy, rd_error;

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag_out  = "R3";
    string tag_err  = "R7";
    bit    model_on = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    adc_serial_port #(.DATA_W(DW), .CONV_CYCLES(CONV)) dut_i (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .mode_sel(mode_sel),
        .sample_in(sample_in), .cs_n(cs_n), .rd_n(rd_n), .sclk(sclk), .sdin(sdin),
        .sdout(sdout), .busy(busy), .rd_error(rd_error)
    );

    // Behavioural reference: history of pin levels, a bit queue, integers.
    logic [3:0] hq[$];
    bit         m_q[$];
    bit         m_busy = 0, m_hold = 0, m_armed = 0, m_err = 0, m_sdout = 0;
    int         m_left = 0, m_nbits = 0;
    logic [DW-1:0] m_result = '0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic [3:0] a, b;
        bit done, rise, fall, reload, en, shift, complete;
        a = hq[1];
        b = hq[2];
        done   = m_busy && m_left == 0;
        rise   = a[0] && !b[0];
        fall   = !a[0] && b[0];
        reload = !a[1] && b[1];
        en     = !a[1] && !a[2];
        shift  = fall && en && !reload;
        complete = (m_nbits >= DW) || (m_nbits == DW - 1 && shift);
        m_err  = done && m_armed && !complete;
        if (done) m_armed = 0;
        else if (reload) m_armed = m_busy && mode_sel;
        if (reload) begin
            m_q.delete();
            for (int i = DW - 1; i >= 0; i--) m_q.push_back(m_result[i]);
            m_nbits = 0;
        end else if (shift) begin
            void'(m_q.pop_front());
            m_q.push_back(m_hold);
            if (m_nbits < DW) m_nbits++;
        end
        if (rise && en) m_hold = mode_sel ? 1'b0 : a[3];
        if (m_busy) begin
            if (m_left == 0) begin m_busy = 0; m_result = sample_in; end
            else m_left--;
        end else if (conv_start) begin
            m_busy = 1; m_left = CONV - 1;
        end
        hq.push_front({sdin, rd_n, cs_n, sclk});
        void'(hq.pop_back());
        m_sdout = hq[1][1] ? 1'b0 : m_q[0];
    endtask

    task automatic tick();
        @(posedge clk);
        if (model_on) model_step();
        @(negedge clk);
        if (model_on) begin
            check(busy == m_busy, "R2", "busy", busy, m_busy);
            check(rd_error == m_err, tag_err, "rd_error", rd_error, m_err);
            check(sdout == m_sdout, tag_out, "sdout", sdout, m_sdout);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic start_conv(input logic [DW-1:0] v);
        sample_in  = v;
        conv_start = 1'b1;
        tick();
        conv_start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) tick();
        tick();
    endtask

    // Read n bits; up supplies sdin MSB first; errs counts rd_error pulses.
    task automatic do_read(input int n, input logic [31:0] up, input bit lower,
                           input bit raise, output logic [31:0] got, output int errs);
        got = '0;
        errs = 0;
        if (lower) begin
            cs_n = 1'b0; rd_n = 1'b0;
            for (int i = 0; i < 4; i++) begin tick(); errs += rd_error; end
        end
        for (int j = 0; j < n; j++) begin
            got  = {got[30:0], sdout};
            sclk = 1'b1;
            sdin = up[31-j];
            for (int i = 0; i < 3; i++) begin tick(); errs += rd_error; end
            sclk = 1'b0;
            for (int i = 0; i < 3; i++) begin tick(); errs += rd_error; end
        end
        sdin = 1'b0;
        if (raise) begin
            cs_n = 1'b1; rd_n = 1'b1;
            for (int i = 0; i < 3; i++) begin tick(); errs += rd_error; end
        end
    endtask

    initial begin
        logic [31:0] got;
        int errs, n;
        for (int i = 0; i < 3; i++) hq.push_back(4'b0110);
        for (int i = 0; i < DW; i++) m_q.push_back(1'b0);
        repeat (4) @(negedge clk);
        // R1: reset state
        check(busy == 0 && rd_error == 0 && sdout == 0, "R1", "outputs in reset",
              {busy, rd_error, sdout}, 0);
        rst_n = 1'b1;
        model_on = 1'b1;
        tick();
        check(busy == 0 && rd_error == 0 && sdout == 0, "R1", "outputs after reset",
              {busy, rd_error, sdout}, 0);

        // R2/R9: conversion length, start request while busy ignored
        mode_sel = 1'b0;
        start_conv(16'hA5C3);
        n = 0;
        while (busy) begin
            conv_start = (n == 50);
            n++;
            tick();
        end
        conv_start = 1'b0;
        check(n == CONV, "R9", "busy length with extra start", n, CONV);
        tick();

        // R3/R5: read-after with chain input
        do_read(32, 32'h1234_0000, 1, 1, got, errs);
        check(got[31:16] == 16'hA5C3, "R3", "local word", got[31:16], 16'hA5C3);
        check(got[15:0] == 16'h1234, "R5", "chained word", got[15:0], 16'h1234);

        // R4: partial read then reselect restarts at MSB
        do_read(5, 32'h0, 1, 1, got, errs);
        do_read(16, 32'h0, 1, 1, got, errs);
        check(got[15:0] == 16'hA5C3, "R4", "reload after reselect", got[15:0], 16'hA5C3);

        // R3: serial clocks with read enable high consume nothing
        cs_n = 1'b0;
        ticks(4);
        for (int k = 0; k < 3; k++) begin
            sclk = 1'b1; ticks(3); sclk = 1'b0; ticks(3);
        end
        check(sdout == 1'b1, "R3", "MSB held with rd_n high", sdout, 1);
        do_read(16, 32'h0, 1, 1, got, errs);
        check(got[15:0] == 16'hA5C3, "R3", "word after idle clocks", got[15:0], 16'hA5C3);

        // R6/R8: read-during gives previous word, sdin ignored
        mode_sel = 1'b1;
        tag_out  = "R8";
        start_conv(16'h0F0F);
        do_read(24, 32'hFFFF_FFFF, 1, 1, got, errs);
        check(got[23:8] == 16'hA5C3, "R6", "previous word", got[23:8], 16'hA5C3);
        check(got[7:0] == 8'h00, "R8", "chain bits blocked", got[7:0], 0);
        check(errs == 0, "R7", "no error on full read", errs, 0);
        wait_idle();

        // R7: short read-during read flags one pulse
        tag_err = "R7";
        start_conv(16'h1111);
        do_read(5, 32'h0, 1, 0, got, errs);
        check(got[4:0] == 5'b00001, "R6", "first bits of previous", got[4:0], 1);
        n = 0;
        while (busy) begin tick(); n += rd_error; end
        ticks(3); n += errs;
        check(n == 1, "R7", "error pulse count", n, 1);
        cs_n = 1'b1; rd_n = 1'b1;
        ticks(3);

        // R11: read-after read spanning the next conversion
        mode_sel = 1'b0;
        tag_out  = "R11";
        tag_err  = "R11";
        do_read(8, 32'h0, 1, 0, got, errs);
        n = errs;
        start_conv(16'h2222);
        do_read(8, 32'h0, 0, 0, got, errs);
        n += errs;
        while (busy) begin tick(); n += rd_error; end
        tick(); n += rd_error;
        check(got[7:0] == 8'h11 && n == 0, "R11", "spanning read", {got[7:0], n[7:0]}, 16'h1100);
        cs_n = 1'b1; rd_n = 1'b1;
        ticks(3);

        // R10: sweep the final falling edge across the completion cycle
        mode_sel = 1'b1;
        tag_out  = "R10";
        tag_err  = "R10";
        for (int off = 0; off < 12; off++) begin
            start_conv(16'(off * 16'h1357) ^ 16'h8001);
            ticks(92 + off);
            do_read(16, 32'h0, 1, 1, got, errs);
            wait_idle();
            ticks(2);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule